// File: doc/BRIEF.md
# Dual-Channel Serial SAR Converter Controller

This block is the digital core of a two-input, 12-bit successive-approximation converter that a host reads over a serial link. The host pulls an active-low select line low to start a cycle. It can then use SCLK edges to clock the conversion, or let the conversion run on the fast system clock. The host reads a channel tag bit followed by the result, most significant bit first. Driving the select line high ends the cycle and puts the block in shutdown.

No command word picks the input. The converted channel swaps on every select cycle, and the first cycle after reset uses channel 0. To read the same input twice, the host runs one extra select cycle in between without reading anything. The block drives the track/hold switch, the mux select line and the trial code for the capacitive DAC, and it takes one comparator bit back. SCLK, the select line and the mode pin are sampled on `clk`, which is also the internal conversion clock.

Top module: `adc_ctl_top`

## Requirements
- R1: On the clock edge that samples `cs_n` high, the block enters shutdown: `dout_oe`, `track` and `conv_done` go to 0 and `dac_code` goes to 0. Only the channel pointer survives.
- R2: The first conversion after reset uses channel 0, so `ch_sel` is 0 and the tag bit is 0.
- R3: Each select-low period takes the channel pointer, and the pointer toggles when `cs_n` returns high, whether or not any data was read. `ch_sel` holds still while `cs_n` stays low.
- R4: In SCLK-clocked mode (`int_mode`=0), `track` is 1 from the edge after `cs_n` falls until the second SCLK falling edge, and it drops on that edge. While tracking, `dac_code` is 0 and `dout` is driven 0.
- R5: In internal mode (`int_mode`=1), `track` drops on the first SCLK falling edge.
- R6: The bits are tried from MSB to LSB. Each trial bit is set to 1 and kept only when `cmp_hi`=1, meaning the input is at or above the DAC level. For an integer input level v, the final `dac_code` equals v.
- R7: In SCLK-clocked mode, the second falling edge puts the tag bit (bit 0 of `ch_sel`) on `dout`. Falling edges 3 to 14 each finish one trial and put that bit on `dout`, MSB first. Later falling edges output 0.
- R8: In internal mode, one trial runs per `clk` cycle after the acquisition ends. Once the result is complete, each SCLK falling edge shifts out the tag bit, then the 12 result bits MSB first, then zeros.
- R9: In internal mode, SCLK falling edges that arrive while the trials are still running leave `dout` at 0.
- R10: `conv_done` rises when the last trial completes. While `cs_n` stays low after that, `conv_done` stays 1 and `dac_code` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the internal conversion clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low select; high means shutdown |
| sclk | input | 1 | Serial clock from the host |
| int_mode | input | 1 | 1 selects internal conversion clock, 0 selects SCLK-clocked conversion |
| cmp_hi | input | 1 | Comparator result: 1 when the input is at or above the DAC level |
| track | output | 1 | Track/hold control, 1 means track |
| ch_sel | output | 1 | Input mux select |
| dac_code | output | 12 | Trial code for the capacitive DAC |
| dout | output | 1 | Serial data value |
| dout_oe | output | 1 | Output enable for the serial data pad (0 means high impedance) |
| conv_done | output | 1 | All trials of the current cycle are complete |

## Verification
Every input is sampled on `clk`, so a select change or an SCLK falling edge seen at one rising edge shows on the outputs right after that same edge. The bench drives inputs at falling `clk` edges and checks one falling edge later. In internal mode, `conv_done` is due 12 `clk` cycles after the acquisition-ending edge, and the loaded readout register is ready one cycle after that. The bench therefore waits 16 cycles before it starts reading. A comparator model recomputes `cmp_hi` from the present `dac_code` at all times, so the trial bits expected on `dout` are simply the bits of the chosen input level.

// File: rtl/adc_ctl_pkg.sv
package adc_ctl_pkg;
  typedef enum logic [1:0] {
    ST_SHDN = 2'd0,
    ST_ACQ  = 2'd1,
    ST_CONV = 2'd2,
    ST_READ = 2'd3
  } adc_state_e;
endpackage

// File: rtl/adc_chan_seq.sv
// Channel pointer: wraps through NCH inputs, one step per select cycle.
module adc_chan_seq #(
  parameter int NCH = 2,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          advance,
  output logic [CW-1:0] ptr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0;
    end else if (advance) begin
      if (ptr == CW'(NCH - 1)) ptr <= '0;
      else                     ptr <= ptr + 1'b1;
    end
  end
endmodule

// File: rtl/adc_sar_engine.sv
// Successive-approximation register: one trial per accepted step.
module adc_sar_engine #(
  parameter int W = 12,
  localparam int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clear,
  input  logic         start,
  input  logic         step,
  input  logic         cmp_hi,
  output logic [W-1:0] code,
  output logic         busy,
  output logic         done,
  output logic         last
);
  logic [IW-1:0] idx;

  assign last = busy && (idx == '0);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      code <= '0;
      idx  <= '0;
      busy <= 1'b0;
      done <= 1'b0;
    end else if (start) begin
      code <= {1'b1, {(W-1){1'b0}}};
      idx  <= IW'(W - 1);
      busy <= 1'b1;
      done <= 1'b0;
    end else if (step && busy) begin
      code[idx] <= cmp_hi;
      if (idx != '0) begin
        code[idx - 1'b1] <= 1'b1;
        idx              <= idx - 1'b1;
      end else begin
        busy <= 1'b0;
        done <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/adc_ctl_top.sv
// Control core: select sequencing, acquisition window, trials, serial out.
module adc_ctl_top
  import adc_ctl_pkg::*;
#(
  parameter int W       = 12,
  parameter int NCH     = 2,
  parameter int ACQ_EXT = 2,
  parameter int ACQ_INT = 1,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_n,
  input  logic          sclk,
  input  logic          int_mode,
  input  logic          cmp_hi,
  output logic          track,
  output logic [CW-1:0] ch_sel,
  output logic [W-1:0]  dac_code,
  output logic          dout,
  output logic          dout_oe,
  output logic          conv_done
);
  localparam int ACQ_MAX = (ACQ_EXT > ACQ_INT) ? ACQ_EXT : ACQ_INT;
  localparam int AW      = $clog2(ACQ_MAX + 1);

  adc_state_e    state;
  logic          sclk_q;
  logic [AW-1:0] acq_cnt;
  logic [W:0]    out_sr;
  logic [CW-1:0] ptr;

  logic sclk_fall, acq_end, eng_clear, eng_start, eng_step, ptr_adv;
  logic eng_busy, eng_done, eng_last;
  logic [AW-1:0] acq_len;

  assign sclk_fall = sclk_q & ~sclk;
  assign acq_len   = int_mode ? AW'(ACQ_INT) : AW'(ACQ_EXT);
  assign acq_end   = (state == ST_ACQ) && !cs_n && sclk_fall
                     && ((acq_cnt + 1'b1) == acq_len);
  assign eng_clear = cs_n || (state == ST_SHDN);
  assign eng_start = acq_end;
  assign eng_step  = (state == ST_CONV) && !cs_n && (int_mode || sclk_fall);
  assign ptr_adv   = cs_n && (state != ST_SHDN);

  adc_chan_seq #(.NCH(NCH)) u_seq (
    .clk     (clk),
    .rst     (rst),
    .advance (ptr_adv),
    .ptr     (ptr)
  );

  adc_sar_engine #(.W(W)) u_sar (
    .clk    (clk),
    .rst    (rst),
    .clear  (eng_clear),
    .start  (eng_start),
    .step   (eng_step),
    .cmp_hi (cmp_hi),
    .code   (dac_code),
    .busy   (eng_busy),
    .done   (eng_done),
    .last   (eng_last)
  );

  assign conv_done = eng_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_SHDN;
      sclk_q  <= 1'b0;
      acq_cnt <= '0;
      out_sr  <= '0;
      track   <= 1'b0;
      ch_sel  <= '0;
      dout    <= 1'b0;
      dout_oe <= 1'b0;
    end else begin
      sclk_q <= sclk;
      if (cs_n) begin
        state   <= ST_SHDN;
        track   <= 1'b0;
        dout    <= 1'b0;
        dout_oe <= 1'b0;
        acq_cnt <= '0;
        out_sr  <= '0;
      end else begin
        unique case (state)
          ST_SHDN: begin
            state   <= ST_ACQ;
            track   <= 1'b1;
            dout_oe <= 1'b1;
            dout    <= 1'b0;
            ch_sel  <= ptr;
            acq_cnt <= '0;
          end
          ST_ACQ: begin
            if (acq_end) begin
              state  <= ST_CONV;
              track  <= 1'b0;
              out_sr <= '0;
              if (!int_mode) dout <= ch_sel[0];
            end else if (sclk_fall) begin
              acq_cnt <= acq_cnt + 1'b1;
            end
          end
          ST_CONV: begin
            if (int_mode) begin
              if (eng_done) begin
                state  <= ST_READ;
                out_sr <= {ch_sel[0], dac_code};
              end
            end else if (sclk_fall && eng_busy) begin
              dout <= cmp_hi;
              if (eng_last) state <= ST_READ;
            end
          end
          ST_READ: begin
            if (sclk_fall) begin
              dout   <= out_sr[W];
              out_sr <= {out_sr[W-1:0], 1'b0};
            end
          end
          default: state <= ST_SHDN;
        endcase
      end
    end
  end
endmodule

// File: rtl/adc_ctl_checker.sv
module adc_ctl_checker #(
  parameter int W   = 12,
  parameter int NCH = 2,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input logic          clk,
  input logic          rst,
  input logic          cs_n,
  input logic          sclk,
  input logic          int_mode,
  input logic          cmp_hi,
  input logic          track,
  input logic [CW-1:0] ch_sel,
  input logic [W-1:0]  dac_code,
  input logic          dout,
  input logic          dout_oe,
  input logic          conv_done
);
  a_r1_shutdown_quiet: assert property (@(posedge clk) disable iff (rst)
    cs_n |=> (!dout_oe && !track && !conv_done && dac_code == '0));

  a_r3_channel_steady: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && dout_oe) |=> $stable(ch_sel));

  a_r4_track_idle_dac: assert property (@(posedge clk) disable iff (rst)
    track |-> (dac_code == '0 && dout_oe && !dout));

  a_r10_done_holds: assert property (@(posedge clk) disable iff (rst)
    (conv_done && !cs_n) |=> (conv_done && $stable(dac_code)));

  a_r10_done_not_tracking: assert property (@(posedge clk) disable iff (rst)
    conv_done |-> !track);
endmodule

bind adc_ctl_top adc_ctl_checker #(.W(W), .NCH(NCH)) u_chk (.*);

// File: tb/tb_adc_ctl_top.sv
module tb_adc_ctl_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cs_n = 1'b1;
  logic        sclk = 1'b1;
  logic        int_mode = 1'b0;
  logic [11:0] vin = '0;
  logic        cmp_hi;
  logic        track, dout, dout_oe, conv_done;
  logic [0:0]  ch_sel;
  logic [11:0] dac_code;
  wire         dout_pin = dout_oe ? dout : 1'bz;
  int checks = 0;
  int errors = 0;
  logic cs_seen = 1'b0;

  always #10 clk = ~clk;

  // ideal comparator against the chosen input level
  assign cmp_hi = (vin >= dac_code);

  adc_ctl_top dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .int_mode(int_mode),
    .cmp_hi(cmp_hi), .track(track), .ch_sel(ch_sel), .dac_code(dac_code),
    .dout(dout), .dout_oe(dout_oe), .conv_done(conv_done)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic fall();
    sclk = 1'b0;
    tick();
  endtask

  task automatic rise();
    sclk = 1'b1;
    tick();
  endtask

  task automatic select_on(input logic exp_ch, input string rq);
    cs_n = 1'b0;
    tick();
    chk({rq, " channel"}, ch_sel, exp_ch);
    chk("R4 track on select", track, 1);
    chk("R4 output enabled", dout_oe, 1);
  endtask

  task automatic select_off();
    cs_n = 1'b1;
    tick();
    chk("R1 oe off", dout_oe, 0);
    chk("R1 code cleared", dac_code, 0);
    chk("R1 done cleared", conv_done, 0);
    tick();
  endtask

  task automatic run_ext(input logic [11:0] v, input logic exp_ch, input string rq);
    vin = v;
    int_mode = 1'b0;
    select_on(exp_ch, rq);
    fall();
    chk("R4 still tracking after 1st fall", track, 1);
    chk("R4 dout low in acquisition", dout, 0);
    rise();
    fall();
    chk("R4 hold at 2nd fall", track, 0);
    chk("R7 tag bit", dout_pin, exp_ch);
    rise();
    for (int i = 11; i >= 0; i--) begin
      fall();
      chk("R7 data bit", dout_pin, v[i]);
      rise();
    end
    chk("R10 done after last trial", conv_done, 1);
    chk("R6 final code", dac_code, v);
    fall();
    chk("R7 trailing zero", dout_pin, 0);
    rise();
    chk("R10 code held", dac_code, v);
    select_off();
  endtask

  task automatic run_int(input logic [11:0] v, input logic exp_ch, input string rq);
    vin = v;
    int_mode = 1'b1;
    select_on(exp_ch, rq);
    fall();
    chk("R5 hold at 1st fall", track, 0);
    chk("R9 dout low", dout_pin, 0);
    rise();
    fall();
    chk("R9 early fall ignored", dout_pin, 0);
    chk("R8 not done yet", conv_done, 0);
    rise();
    repeat (16) tick();
    chk("R8 done", conv_done, 1);
    chk("R6 final code", dac_code, v);
    chk("R9 dout still low", dout_pin, 0);
    fall();
    chk("R8 tag bit", dout_pin, exp_ch);
    rise();
    for (int i = 11; i >= 0; i--) begin
      fall();
      chk("R8 data bit", dout_pin, v[i]);
      rise();
    end
    fall();
    chk("R8 trailing zero", dout_pin, 0);
    rise();
    select_off();
  endtask

  // R1: outputs quiet after every edge that sampled the select high
  always @(posedge clk) cs_seen <= cs_n & ~rst;
  always @(negedge clk) begin
    if (cs_seen) begin
      chk("R1 shutdown oe", dout_oe, 0);
      chk("R1 shutdown track", track, 0);
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    tick();
    chk("R1 reset oe", dout_oe, 0);
    chk("R1 reset track", track, 0);
    chk("R1 reset done", conv_done, 0);
    chk("R2 reset channel", ch_sel, 0);

    run_ext(12'h800, 1'b0, "R2");
    run_ext(12'hA5A, 1'b1, "R3");
    run_int(12'h123, 1'b0, "R3");
    run_int(12'hFFF, 1'b1, "R3");
    // unread cycle on channel 0 still advances the pointer
    select_on(1'b0, "R3");
    select_off();
    run_ext(12'h000, 1'b1, "R3");
    // repeat channel 1 by burning one select cycle
    select_on(1'b0, "R3");
    select_off();
    run_ext(12'h7FF, 1'b1, "R3");
    run_int(12'h5A5, 1'b0, "R3");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule